// File: doc/BRIEF.md
# Eight-Pin Configurable I/O Port with Interrupt Detection

The block is an eight-pin general-purpose I/O port. Four per-pin configuration registers (data, direction, alternate-select low, alternate-select high) are written through a small register interface. The bits at the same position in all four registers form one 4-bit code, {altHi, altLo, dir, data}, and that code sets what the pin does. The available behaviours are push-pull output, input, open-drain, open-source, handing the pin to an alternate function, edge-triggered interrupts and level-sensitive interrupts.

Every pin drives a data value, an output enable and an alternate-function select toward its pad. Pin inputs arrive asynchronously and pass through a two-stage synchronizer. The data bit has two roles: it is the drive value in the output modes, and it selects polarity or edge in the interrupt modes. The block combines all pending interrupt requests into one request line. Firmware clears an edge event by writing 1 to that pin's bit of the data register.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted, and right after it, every pin is in input mode (code 0010): direction register reads 0xFF, data/altLo/altHi registers hold 0, padOe = 0, padOut = 0, altSel = 0 and irq = 0.
- R2: Codes 000x (push-pull) set padOe = 1 and padOut = data bit, in the same cycle the register is written.
- R3: Codes 001x (input) set padOe = 0 and padOut = 0 for either value of the data bit.
- R4: A read with regSel = 0 returns the synchronized pin levels, which follow pinIn two clock edges later, in every mode and never the stored data bits.
- R5: Codes 010x (open-drain) set padOut = 0 and padOe = NOT data bit.
- R6: Codes 011x (open-source) set padOut = 1 and padOe = data bit.
- R7: Codes 110x set altSel = 1 with padOe = 0. All other codes give altSel = 0.
- R8: Code 1110 requests an interrupt while the synchronized pin is low, and code 1111 requests one while it is high. The request is not stored and drops when the level goes away. padOe = 0.
- R9: Code 1000 latches a per-pin flag on a falling edge of the synchronized pin, and code 1001 latches one on a rising edge. padOe = 0. The flag raises irq one cycle after the synchronized edge.
- R10: Codes 101x latch the flag on either edge, with padOe = 0.
- R11: When the data register is written, a pin in an edge mode (100x, 101x) has its flag cleared where the written bit is 1, and its stored data bit is left unchanged. A new edge in the same cycle as the clear wins over the clear.
- R12: A pin that leaves the edge modes loses its flag. irq is the OR of all latched edge flags of pins in edge modes and all active level requests.
- R13: regSel 1, 2 and 3 read back the direction, altLo and altHi registers. regWr with regSel selects exactly one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 2 | Register select: 0 data, 1 direction, 2 altLo, 3 altHi |
| regWr | input | 1 | Write strobe for the selected register |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data of the selected register (pin levels for data) |
| pinIn | input | 8 | Asynchronous pin levels from the pads |
| padOut | output | 8 | Per-pin output value |
| padOe | output | 8 | Per-pin output enable |
| altSel | output | 8 | Per-pin alternate-function select |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench aims at the double role of the data bit. A data write to a pin in edge mode must clear that pin's flag without changing its edge polarity. A design that stores the written value would flip a falling-edge pin to rising and miss the next falling edge. The bench also shows that a read of the data register returns pin levels rather than stored bits, which a design that returns the register would fail at once. It checks that level interrupts drop as soon as the level is gone, and that flags vanish when a pin leaves edge mode. A design that latched level requests, or kept a stale flag, would leave irq stuck high.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_ALTL = 2'd2,
    SEL_ALTH = 2'd3
  } regSelE;

  typedef struct packed {
    logic dataWr;
    logic dirWr;
    logic altLoWr;
    logic altHiWr;
  } wrStrobeT;

  typedef enum logic [2:0] {
    PM_PUSH,
    PM_INPUT,
    PM_ODRAIN,
    PM_OSRC,
    PM_EDGE1,
    PM_EDGE2,
    PM_ALT,
    PM_LEVEL
  } pinModeE;

  function automatic pinModeE decodeMode(logic altHi, logic altLo, logic dir);
    case ({altHi, altLo, dir})
      3'b000:  return PM_PUSH;
      3'b001:  return PM_INPUT;
      3'b010:  return PM_ODRAIN;
      3'b011:  return PM_OSRC;
      3'b100:  return PM_EDGE1;
      3'b101:  return PM_EDGE2;
      3'b110:  return PM_ALT;
      default: return PM_LEVEL;
    endcase
  endfunction

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [1:0]       regSel,
  input  logic             regWr,
  input  logic [WIDTH-1:0] dataQ,
  input  logic [WIDTH-1:0] dirQ,
  input  logic [WIDTH-1:0] altLoQ,
  input  logic [WIDTH-1:0] altHiQ,
  input  logic [WIDTH-1:0] pinLevel,
  output wrStrobeT         strobe,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] unusedData;
  assign unusedData = dataQ;

  always_comb begin
    strobe = '0;
    if (regWr) begin
      case (regSelE'(regSel))
        SEL_DATA: strobe.dataWr  = 1'b1;
        SEL_DIR:  strobe.dirWr   = 1'b1;
        SEL_ALTL: strobe.altLoWr = 1'b1;
        default:  strobe.altHiWr = 1'b1;
      endcase
    end
  end

  always_comb begin
    case (regSelE'(regSel))
      SEL_DATA: rdata = pinLevel;
      SEL_DIR:  rdata = dirQ;
      SEL_ALTL: rdata = altLoQ;
      default:  rdata = altHiQ;
    endcase
  end

  always_comb begin
    assert_single_strobe_R13: assert ($onehot0(strobe))
      else $error("more than one register write strobe active");
  end

endmodule

// File: rtl/gpio_port_dpath.sv
module gpio_port_dpath
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  wrStrobeT         strobe,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] dataQ,
  output logic [WIDTH-1:0] dirQ,
  output logic [WIDTH-1:0] altLoQ,
  output logic [WIDTH-1:0] altHiQ,
  output logic [WIDTH-1:0] pinLevel,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] altSel,
  output logic             irq
);

  logic [WIDTH-1:0] syncA, syncB, prevLevel;
  logic [WIDTH-1:0] edgeMask, edgeEvt, levelHit, edgeFlag, clearMask;
  logic [WIDTH-1:0] riseV, fallV;

  // configuration registers; edge-mode data bits keep their polarity on writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ  <= '0;
      dirQ   <= '1;
      altLoQ <= '0;
      altHiQ <= '0;
    end else begin
      if (strobe.dataWr)  dataQ  <= (wdata & ~edgeMask) | (dataQ & edgeMask);
      if (strobe.dirWr)   dirQ   <= wdata;
      if (strobe.altLoWr) altLoQ <= wdata;
      if (strobe.altHiWr) altHiQ <= wdata;
    end
  end

  // two-stage synchronizer plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA     <= '0;
      syncB     <= '0;
      prevLevel <= '0;
    end else begin
      syncA     <= pinIn;
      syncB     <= syncA;
      prevLevel <= syncB;
    end
  end

  assign pinLevel = syncB;
  assign riseV    = syncB & ~prevLevel;
  assign fallV    = ~syncB & prevLevel;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_pin
      pinModeE mode;
      assign mode = decodeMode(altHiQ[gi], altLoQ[gi], dirQ[gi]);

      assign padOe[gi]    = (mode == PM_PUSH)
                          | ((mode == PM_ODRAIN) & ~dataQ[gi])
                          | ((mode == PM_OSRC) & dataQ[gi]);
      assign padOut[gi]   = ((mode == PM_PUSH) & dataQ[gi]) | (mode == PM_OSRC);
      assign altSel[gi]   = (mode == PM_ALT);
      assign edgeMask[gi] = (mode == PM_EDGE1) | (mode == PM_EDGE2);
      assign edgeEvt[gi]  = ((mode == PM_EDGE2) & (riseV[gi] | fallV[gi]))
                          | ((mode == PM_EDGE1) & (dataQ[gi] ? riseV[gi] : fallV[gi]));
      assign levelHit[gi] = (mode == PM_LEVEL) & (syncB[gi] ~^ dataQ[gi]);
    end
  endgenerate

  assign clearMask = strobe.dataWr ? (wdata & edgeMask) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeFlag <= '0;
    else       edgeFlag <= (edgeFlag & ~clearMask & edgeMask) | edgeEvt;
  end

  assign irq = (|(edgeFlag & edgeMask)) | (|levelHit);

  // synchronized level tracks the pad two edges later
  property pSyncDelay;
    @(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(rstN, 2)) |-> (syncB == $past(pinIn, 2));
  endproperty
  assert_sync_delay_R4: assert property (pSyncDelay)
    else $error("synchronized level does not follow pin input");

  // a qualifying edge is latched on the next edge
  property pFlagSet;
    @(posedge clk) disable iff (!rstN)
      (|edgeEvt) |=> ((edgeFlag & $past(edgeEvt)) == $past(edgeEvt));
  endproperty
  assert_flag_set_R9: assert property (pFlagSet)
    else $error("edge event not latched");

  // flags persist while in edge mode and not cleared
  property pFlagSticky;
    @(posedge clk) disable iff (!rstN)
      1'b1 |=> (($past(edgeFlag & edgeMask & ~clearMask) & ~edgeFlag) == '0);
  endproperty
  assert_flag_sticky_R11: assert property (pFlagSticky)
    else $error("edge flag lost without a clear");

  // data bits of edge-mode pins keep their polarity across data writes
  property pPolarityHold;
    @(posedge clk) disable iff (!rstN)
      strobe.dataWr |=> ((dataQ & $past(edgeMask)) == $past(dataQ & edgeMask));
  endproperty
  assert_polarity_hold_R11: assert property (pPolarityHold)
    else $error("edge polarity changed by a data write");

  // no latched flag survives one cycle outside edge mode
  property pFlagDrop;
    @(posedge clk) disable iff (!rstN)
      1'b1 |=> ((edgeFlag & ~$past(edgeMask) & ~$past(edgeEvt)) == '0);
  endproperty
  assert_flag_drop_R12: assert property (pFlagDrop)
    else $error("flag kept outside edge mode");

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regSel,
  input  logic             regWr,
  input  logic [WIDTH-1:0] regWdata,
  output logic [WIDTH-1:0] regRdata,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] altSel,
  output logic             irq
);

  wrStrobeT         strobe;
  logic [WIDTH-1:0] dataQ, dirQ, altLoQ, altHiQ, pinLevel;

  gpio_port_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .regSel   (regSel),
    .regWr    (regWr),
    .dataQ    (dataQ),
    .dirQ     (dirQ),
    .altLoQ   (altLoQ),
    .altHiQ   (altHiQ),
    .pinLevel (pinLevel),
    .strobe   (strobe),
    .rdata    (regRdata)
  );

  gpio_port_dpath #(.WIDTH(WIDTH)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wdata    (regWdata),
    .pinIn    (pinIn),
    .dataQ    (dataQ),
    .dirQ     (dirQ),
    .altLoQ   (altLoQ),
    .altHiQ   (altHiQ),
    .pinLevel (pinLevel),
    .padOut   (padOut),
    .padOe    (padOe),
    .altSel   (altSel),
    .irq      (irq)
  );

endmodule

// File: tb/gpio_port_tb_top.sv
`timescale 1ns/1ps
module gpio_port_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic       regWr = 1'b0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] pinIn = 8'd0;
  logic [7:0] regRdata, padOut, padOe, altSel;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  gpio_port dut_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .pinIn(pinIn),
    .padOut(padOut), .padOe(padOe), .altSel(altSel), .irq(irq)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0] mData, mDir, mLo, mHi, mS1, mS2, mPrev, mFlag;

  function automatic int codeOf(int i);
    return {mHi[i], mLo[i], mDir[i], mData[i]};
  endfunction

  function automatic bit isEdge(int c);
    return (c >= 8) && (c <= 11);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mData <= 8'h00; mDir <= 8'hFF; mLo <= 8'h00; mHi <= 8'h00;
      mS1 <= 8'h00; mS2 <= 8'h00; mPrev <= 8'h00; mFlag <= 8'h00;
    end else begin
      logic [7:0] nData, nFlag;
      nData = mData;
      nFlag = mFlag;
      for (int i = 0; i < 8; i++) begin
        int c;
        bit ev;
        bit clr;
        c  = codeOf(i);
        ev = 1'b0;
        if (c == 8)  ev = mPrev[i] && !mS2[i];
        if (c == 9)  ev = !mPrev[i] && mS2[i];
        if (c == 10 || c == 11) ev = mPrev[i] != mS2[i];
        clr = regWr && regSel == 2'd0 && regWdata[i];
        if (isEdge(c)) nFlag[i] = (mFlag[i] && !clr) || ev;
        else           nFlag[i] = 1'b0;
        if (regWr && regSel == 2'd0 && !isEdge(c)) nData[i] = regWdata[i];
      end
      mData <= nData;
      mFlag <= nFlag;
      if (regWr && regSel == 2'd1) mDir <= regWdata;
      if (regWr && regSel == 2'd2) mLo  <= regWdata;
      if (regWr && regSel == 2'd3) mHi  <= regWdata;
      mS1   <= pinIn;
      mS2   <= mS1;
      mPrev <= mS2;
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!done) begin
      logic [7:0] eOut, eOe, eAlt, eRd;
      bit eIrq;
      eOut = 0; eOe = 0; eAlt = 0; eIrq = 0;
      for (int i = 0; i < 8; i++) begin
        int c;
        c = codeOf(i);
        case (c)
          0:  begin eOe[i] = 1; eOut[i] = 0; end
          1:  begin eOe[i] = 1; eOut[i] = 1; end
          4:  eOe[i] = 1;
          6:  eOut[i] = 1;
          7:  begin eOe[i] = 1; eOut[i] = 1; end
          12, 13: eAlt[i] = 1;
          14: if (!mS2[i]) eIrq = 1;
          15: if (mS2[i])  eIrq = 1;
          default: ;
        endcase
        if (isEdge(c) && mFlag[i]) eIrq = 1;
      end
      case (regSel)
        2'd0: eRd = mS2;
        2'd1: eRd = mDir;
        2'd2: eRd = mLo;
        default: eRd = mHi;
      endcase
      check("R2 padOut model", padOut, eOut);
      check("R3 padOe model", padOe, eOe);
      check("R7 altSel model", altSel, eAlt);
      check("R12 irq model", {7'd0, irq}, {7'd0, eIrq});
      check("R4 regRdata model", regRdata, eRd);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(logic [1:0] sel, logic [7:0] d);
    @(negedge clk);
    regSel = sel; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0; regSel = 2'd0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [1:0] sel, string tag, logic [7:0] exp);
    regSel = sel;
    #1;
    check(tag, regRdata, exp);
    regSel = 2'd0;
  endtask

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    check("R1 padOe in reset", padOe, 8'h00);
    check("R1 irq in reset", {7'd0, irq}, 8'h00);
    rstN = 1'b1;
    idle(1);
    rd(2'd1, "R1 dir after reset", 8'hFF);
    rd(2'd3, "R13 altHi readback", 8'h00);

    pinIn = 8'hA5; idle(3);
    rd(2'd0, "R4 pin level read", 8'hA5);

    wr(2'd0, 8'h3C);
    check("R3 input ignores data", padOe, 8'h00);
    rd(2'd0, "R4 read not data reg", 8'hA5);
    wr(2'd1, 8'h00);
    check("R2 push-pull oe", padOe, 8'hFF);
    check("R2 push-pull out", padOut, 8'h3C);
    rd(2'd1, "R13 dir readback", 8'h00);

    wr(2'd1, 8'hFF);
    check("R3 input oe", padOe, 8'h00);

    wr(2'd2, 8'hFF); wr(2'd1, 8'h00);
    check("R5 open-drain oe", padOe, 8'hC3);
    check("R5 open-drain out", padOut, 8'h00);

    wr(2'd1, 8'hFF);
    check("R6 open-source oe", padOe, 8'h3C);
    check("R6 open-source out", padOut, 8'hFF);

    wr(2'd1, 8'h00); wr(2'd3, 8'hFF);
    check("R7 alternate select", altSel, 8'hFF);
    check("R7 alternate oe", padOe, 8'h00);

    wr(2'd1, 8'hFF);
    check("R7 level no altSel", altSel, 8'h00);
    check("R8 level match irq", {7'd0, irq}, 8'h01);
    pinIn = 8'hC3; idle(3);
    check("R8 level not latched", {7'd0, irq}, 8'h00);

    pinIn = 8'h00; idle(3);
    wr(2'd0, 8'h0F);
    wr(2'd2, 8'h00); idle(2);
    wr(2'd1, 8'h00); idle(2);
    check("R9 edge idle irq", {7'd0, irq}, 8'h00);
    check("R9 edge oe", padOe, 8'h00);
    pinIn = 8'hFF; idle(4);
    check("R9 rising edge irq", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'hFF);
    check("R11 clear flags", {7'd0, irq}, 8'h00);
    pinIn = 8'h00; idle(4);
    check("R11 polarity kept", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'h0F);
    check("R11 partial clear", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'hF0);
    check("R11 full clear", {7'd0, irq}, 8'h00);

    wr(2'd1, 8'hFF); idle(2);
    pinIn = 8'h01; idle(4);
    check("R10 dual rise", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'h01);
    check("R10 dual clear", {7'd0, irq}, 8'h00);
    pinIn = 8'h00; idle(4);
    check("R10 dual fall", {7'd0, irq}, 8'h01);

    wr(2'd3, 8'h00);
    check("R12 leave edge mode", {7'd0, irq}, 8'h00);
    wr(2'd3, 8'hFF); idle(2);
    check("R12 flag not restored", {7'd0, irq}, 8'h00);
    rd(2'd2, "R13 altLo readback", 8'h00);

    idle(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule